// File: doc/BRIEF.md
# PWM Frequency Dither Retimer

This block takes a pulse-width-modulated signal produced elsewhere, with a fixed period and a duty ratio that drifts slowly. It sends each cycle back out with its period stretched or shrunk by a small, cycle-by-cycle amount, so the switching energy spreads over a band a few kilohertz wide. The duty ratio of each cycle is kept. The input is sampled on a fixed-rate sample tick. Each complete cycle, from one rising edge to the next, is stored as two counts: high samples and total samples. The stored cycle is then played back against a second tick whose rate comes from a phase accumulator.

The accumulator increment is the nominal value plus a signed rate step. The nominal value is chosen so that a step of zero reproduces the sample rate. The step is taken only when one output cycle ends and the next begins, and the same tick paces both the high time and the period, so both scale by the same factor. A cycle that has just been captured waits in a single pending slot until the next output boundary. If nothing new is waiting at that boundary, the last cycle is played again. The sequence that feeds the rate step is produced outside this block.

The pins carry plain levels and no stream traffic, so there is no valid/ready handshake and no back-pressure. The output never stalls the input. A capture that finds the pending slot still occupied replaces what is there.

Top module: `pwm_dither_retimer`

## Requirements
- R1: `pwm_in` passes through two flip-flops and is then sampled once every CAP_DIV clocks. A captured cycle has a period equal to the number of samples from one high-after-low sample up to the next, and a high count equal to the number of high samples in that span.
- R2: During an output cycle, `pwm_out` is high for the first `hi` replay ticks and low for the remaining `per - hi` ticks, with `hi` and `per` being the counts of the stored cycle. With a rate step of zero, the output cycle lasts exactly per*CAP_DIV clocks and is high for exactly hi*CAP_DIV clocks.
- R3: A replay tick is the carry out of an ACC_W-bit phase accumulator. The increment is 2^ACC_W/CAP_DIV plus the rate step, so an output cycle of `per` ticks lasts per*2^ACC_W/increment clocks, within one clock.
- R4: `rate_step` is sampled only in the clock where the last tick of an output cycle occurs. Changes at any other time have no effect on the cycle in progress.
- R5: The rate step is saturated to the range -MAX_STEP to +MAX_STEP, read as two's complement, before it is added to the increment.
- R6: A newly captured cycle is held pending and is loaded into playback only at the next output cycle boundary. If a newer capture arrives while one is still pending, the newer one replaces it.
- R7: If nothing new is pending at a boundary, the cycle that was playing is repeated unchanged.
- R8: After reset, the block plays a cycle of RST_PER ticks with a high count of zero, which gives a constant-low output, at nominal rate until the first capture is loaded. During reset, both outputs are low.
- R9: `cycle_start` is high for exactly one clock, the first clock of each new output cycle.
- R10: If CNT_W-bit counting reaches 2^CNT_W-1 samples and no rising edge has been seen, the cycle in progress is dropped. The next rising edge only re-arms capture and produces no cycle.
- R11: The first rising edge after reset only arms capture. No cycle is produced until the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Incoming PWM, asynchronous to clk |
| rate_step | input | STEP_W | Signed per-cycle offset to the replay increment |
| pwm_out | output | 1 | Retimed PWM |
| cycle_start | output | 1 | One-clock strobe on the first clock of each output cycle |

## Verification
The bench builds the block with CAP_DIV=4, ACC_W=8, CNT_W=8, STEP_W=7, MAX_STEP=16 and RST_PER=8. With a nominal increment of 64, a zero step gives a replay tick exactly every four clocks, so the zero-step output timing can be predicted to the exact clock. The 8-bit counters make the overflow drop happen after roughly a thousand clocks of silence. A 7-bit step with a limit of 16 lets inputs such as ±60 exercise saturation. Short input periods combined with a slow replay rate force captures to overwrite one another in the pending slot.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  // capture arming state
  typedef enum logic {
    CAP_WAIT = 1'b0,
    CAP_RUN  = 1'b1
  } cap_st_e;

endpackage

// File: rtl/pdr_capture.sv
module pdr_capture
  import pdr_pkg::*;
#(
  parameter int unsigned CAP_DIV = 8,
  parameter int unsigned CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  output logic             cap_vld,
  output logic [CNT_W-1:0] cap_hi,
  output logic [CNT_W-1:0] cap_per
);

  localparam int unsigned PRE_W = (CAP_DIV > 1) ? $clog2(CAP_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_END = PRE_W'(CAP_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sy_a, sy_b, last_smp;
  logic [PRE_W-1:0] pre;
  logic             smp_en, rise;
  logic [CNT_W-1:0] p_cnt, h_cnt;
  cap_st_e          st;

  assign smp_en = (pre == PRE_END);
  assign rise   = smp_en & sy_b & ~last_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_a     <= 1'b0;
      sy_b     <= 1'b0;
      last_smp <= 1'b0;
      pre      <= '0;
      p_cnt    <= '0;
      h_cnt    <= '0;
      st       <= CAP_WAIT;
      cap_vld  <= 1'b0;
      cap_hi   <= '0;
      cap_per  <= '0;
    end else begin
      sy_a    <= pwm_in;
      sy_b    <= sy_a;
      cap_vld <= 1'b0;
      pre     <= smp_en ? '0 : pre + PRE_W'(1);
      if (smp_en) begin
        last_smp <= sy_b;
        if (rise) begin
          if (st == CAP_RUN) begin
            cap_vld <= 1'b1;
            cap_hi  <= h_cnt;
            cap_per <= p_cnt;
          end
          st    <= CAP_RUN;
          p_cnt <= CNT_W'(1);
          h_cnt <= CNT_W'(1);
        end else if (p_cnt == CNT_MAX) begin
          st <= CAP_WAIT;
        end else begin
          p_cnt <= p_cnt + CNT_W'(1);
          h_cnt <= h_cnt + {{(CNT_W-1){1'b0}}, sy_b};
        end
      end
    end
  end

  // R1
  cap_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> (cap_hi != '0 && cap_hi < cap_per));

endmodule

// File: rtl/pdr_phase.sv
module pdr_phase #(
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned CAP_DIV  = 8,
  parameter int unsigned STEP_W   = 12,
  parameter int unsigned MAX_STEP = 682
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [STEP_W-1:0] step,
  input  logic                     load,
  output logic                     tick
);

  localparam int unsigned NOM = (2 ** ACC_W) / CAP_DIV;
  localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM);
  localparam logic [ACC_W-1:0] INC_LO = ACC_W'(NOM - MAX_STEP);
  localparam logic [ACC_W-1:0] INC_HI = ACC_W'(NOM + MAX_STEP);
  localparam logic signed [STEP_W-1:0] LIM_P = STEP_W'(MAX_STEP);
  localparam logic signed [STEP_W-1:0] LIM_N = -LIM_P;

  logic signed [STEP_W-1:0] st_c;
  logic [ACC_W-1:0]         st_ext, inc, inc_nx, acc;
  logic [ACC_W:0]           acc_sum;

  always_comb begin
    if (step > LIM_P)      st_c = LIM_P;
    else if (step < LIM_N) st_c = LIM_N;
    else                   st_c = step;
  end

  assign st_ext  = {{(ACC_W-STEP_W){st_c[STEP_W-1]}}, st_c};
  assign inc_nx  = NOM_V + st_ext;
  assign acc_sum = {1'b0, acc} + {1'b0, inc};
  assign tick    = acc_sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      inc <= NOM_V;
    end else begin
      acc <= acc_sum[ACC_W-1:0];
      if (load) inc <= inc_nx;
    end
  end

  // R5
  inc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc >= INC_LO && inc <= INC_HI));

  // R4
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> (inc == $past(inc)));

endmodule

// File: rtl/pdr_replay.sv
module pdr_replay #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned RST_PER = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_vld,
  input  logic [CNT_W-1:0] cap_hi,
  input  logic [CNT_W-1:0] cap_per,
  input  logic             tick,
  output logic             bnd,
  output logic             pwm_out,
  output logic             cycle_start
);

  localparam logic [CNT_W-1:0] START_CNT = '0;

  logic [CNT_W-1:0] r_cnt, stop_cnt, act_per, pend_hi, pend_per;
  logic             pend_vld, cs_q;

  assign bnd         = tick && (r_cnt == act_per - CNT_W'(1));
  assign pwm_out     = (r_cnt >= START_CNT) && (r_cnt < stop_cnt);
  assign cycle_start = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt    <= '0;
      stop_cnt <= '0;
      act_per  <= CNT_W'(RST_PER);
      pend_hi  <= '0;
      pend_per <= '0;
      pend_vld <= 1'b0;
      cs_q     <= 1'b0;
    end else begin
      cs_q <= bnd;
      if (tick) r_cnt <= bnd ? '0 : r_cnt + CNT_W'(1);
      if (bnd && pend_vld) begin
        stop_cnt <= pend_hi;
        act_per  <= pend_per;
        pend_vld <= 1'b0;
      end
      if (cap_vld) begin
        pend_hi  <= cap_hi;
        pend_per <= cap_per;
        pend_vld <= 1'b1;
      end
    end
  end

  // R6
  act_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per != $past(act_per) || stop_cnt != $past(stop_cnt)) |-> $past(bnd));

  // R9
  cs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (r_cnt == '0));

  // R2
  rcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt < act_per);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_vld) && !$past(bnd)) |-> pend_vld);

endmodule

// File: rtl/pwm_dither_retimer.sv
module pwm_dither_retimer #(
  parameter int unsigned CAP_DIV  = 8,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned STEP_W   = 12,
  parameter int unsigned MAX_STEP = 682,
  parameter int unsigned RST_PER  = 500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwm_in,
  input  logic signed [STEP_W-1:0] rate_step,
  output logic                     pwm_out,
  output logic                     cycle_start
);

  logic             cap_vld, rp_tick, rp_bnd;
  logic [CNT_W-1:0] cap_hi, cap_per;

  pdr_capture #(.CAP_DIV(CAP_DIV), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .cap_vld(cap_vld), .cap_hi(cap_hi), .cap_per(cap_per)
  );

  pdr_phase #(.ACC_W(ACC_W), .CAP_DIV(CAP_DIV), .STEP_W(STEP_W),
              .MAX_STEP(MAX_STEP)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(rate_step),
    .load(rp_bnd), .tick(rp_tick)
  );

  pdr_replay #(.CNT_W(CNT_W), .RST_PER(RST_PER)) u_replay (
    .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_hi(cap_hi),
    .cap_per(cap_per), .tick(rp_tick), .bnd(rp_bnd),
    .pwm_out(pwm_out), .cycle_start(cycle_start)
  );

endmodule

// File: tb/test_pwm_dither_retimer.sv
module test_pwm_dither_retimer;

  localparam int CAP_DIV  = 4;
  localparam int ACC_W    = 8;
  localparam int CNT_W    = 8;
  localparam int STEP_W   = 7;
  localparam int MAX_STEP = 16;
  localparam int RST_PER  = 8;
  localparam int FULL     = 1 << ACC_W;
  localparam int NOM      = FULL / CAP_DIV;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in;
  logic signed [STEP_W-1:0] rate_step = '0;
  logic pwm_out, cycle_start;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R2";

  int gen_hi = 12, gen_per = 40, gen_cycles = 0;

  always #5 clk = ~clk;

  pwm_dither_retimer #(
    .CAP_DIV(CAP_DIV), .ACC_W(ACC_W), .CNT_W(CNT_W), .STEP_W(STEP_W),
    .MAX_STEP(MAX_STEP), .RST_PER(RST_PER)
  ) i_pwm_dither_retimer (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .rate_step(rate_step),
    .pwm_out(pwm_out), .cycle_start(cycle_start)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int s);
    if (s > MAX_STEP) return MAX_STEP;
    if (s < -MAX_STEP) return -MAX_STEP;
    return s;
  endfunction

  // behavioural reference model
  int m_s1, m_s2, m_prev, m_pre, m_armed, m_p, m_h, m_cv, m_chi, m_cper;
  int m_acc, m_inc, m_r, m_hi, m_per, m_cs;
  int pq_hi[$], pq_per[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pre = 0; m_armed = 0;
      m_p = 0; m_h = 0; m_cv = 0; m_chi = 0; m_cper = 0;
      m_acc = 0; m_inc = NOM; m_r = 0; m_hi = 0; m_per = RST_PER; m_cs = 0;
      pq_hi.delete(); pq_per.delete();
    end else begin
      int smp, rs, sum, rt, bd, ncv;
      smp = (m_pre == CAP_DIV - 1);
      rs  = smp && m_s2 && !m_prev;
      sum = m_acc + m_inc;
      rt  = (sum >= FULL);
      bd  = rt && (m_r == m_per - 1);
      m_cs = bd;
      if (rt) m_r = bd ? 0 : m_r + 1;
      if (bd && pq_hi.size() > 0) begin
        m_hi = pq_hi.pop_front();
        m_per = pq_per.pop_front();
      end
      if (m_cv) begin
        pq_hi.delete(); pq_per.delete();
        pq_hi.push_back(m_chi); pq_per.push_back(m_cper);
      end
      m_acc = sum % FULL;
      if (bd) m_inc = NOM + clampi(int'(rate_step));
      ncv = 0;
      if (smp) begin
        if (rs) begin
          if (m_armed) begin ncv = 1; m_chi = m_h; m_cper = m_p; end
          m_armed = 1; m_p = 1; m_h = 1;
        end else if (m_p == CNT_MAX) begin
          m_armed = 0;
        end else begin
          m_p++; m_h += m_s2;
        end
        m_prev = m_s2;
      end
      m_cv = ncv;
      m_pre = smp ? 0 : m_pre + 1;
      m_s2 = m_s1;
      m_s1 = pwm_in;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ep;
      ep = (m_r < m_hi);
      chk(pwm_out === 1'(ep), cur_req, "pwm_out vs model", int'(pwm_out), ep);
      chk(cycle_start === 1'(m_cs), "R9", "cycle_start vs model",
          int'(cycle_start), m_cs);
    end
  end

  // input PWM generator
  initial begin
    pwm_in = 1'b0;
    forever begin
      if (gen_cycles != 0) begin
        int hi, pr;
        hi = gen_hi;
        pr = gen_per;
        if (gen_cycles > 0) gen_cycles--;
        for (int k = 0; k < pr; k++) begin
          pwm_in = (k < hi);
          @(negedge clk);
        end
      end else begin
        pwm_in = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic meas(output int pc, output int hc);
    pc = 0; hc = 0;
    do @(negedge clk); while (cycle_start !== 1'b1);
    do begin
      pc++;
      if (pwm_out === 1'b1) hc++;
      @(negedge clk);
    end while (cycle_start !== 1'b1);
  endtask

  task automatic near(input string req, input string what, input int clocks,
                      input int ticks, input int inc);
    int d;
    d = clocks * inc - ticks * FULL;
    if (d < 0) d = -d;
    chk(d <= inc, req, what, clocks, (ticks * FULL) / inc);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int pc, hc;
    wait_clk(5);
    chk(pwm_out === 1'b0, "R8", "pwm_out in reset", int'(pwm_out), 0);
    chk(cycle_start === 1'b0, "R8", "cycle_start in reset", int'(cycle_start), 0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R8";
    meas(pc, hc);
    chk(pc == RST_PER * CAP_DIV, "R8", "reset cycle clocks", pc, RST_PER * CAP_DIV);
    chk(hc == 0, "R8", "reset cycle high clocks", hc, 0);
    chk(pc == RST_PER * CAP_DIV, "R3", "zero step nominal rate", pc, RST_PER * CAP_DIV);

    cur_req = "R11";
    gen_hi = 12; gen_per = 40; gen_cycles = 1;
    wait_clk(300);
    meas(pc, hc);
    chk(pc == RST_PER * CAP_DIV, "R11", "single edge gives no cycle", pc, RST_PER * CAP_DIV);
    chk(hc == 0, "R11", "single edge high clocks", hc, 0);

    cur_req = "R1";
    gen_cycles = -1;
    wait_clk(400);
    meas(pc, hc);
    chk(pc == 40, "R1", "captured period", pc, 40);
    chk(hc == 12, "R1", "captured high", hc, 12);

    cur_req = "R2";
    gen_hi = 28;
    wait_clk(400);
    meas(pc, hc);
    chk(pc == 40, "R2", "replay period", pc, 40);
    chk(hc == 28, "R2", "replay high", hc, 28);

    cur_req = "R3";
    rate_step = 7'sd8;
    wait_clk(150);
    meas(pc, hc);
    near("R3", "period step +8", pc, 10, NOM + 8);
    near("R3", "high step +8", hc, 7, NOM + 8);

    cur_req = "R5";
    rate_step = 7'sd60;
    wait_clk(150);
    meas(pc, hc);
    near("R5", "period step +60 clamped", pc, 10, NOM + MAX_STEP);
    near("R5", "high step +60 clamped", hc, 7, NOM + MAX_STEP);
    rate_step = -7'sd60;
    wait_clk(150);
    meas(pc, hc);
    near("R5", "period step -60 clamped", pc, 10, NOM - MAX_STEP);
    near("R5", "high step -60 clamped", hc, 7, NOM - MAX_STEP);

    cur_req = "R4";
    for (int k = 0; k < 800; k++) begin
      rate_step = (k % 2 == 0) ? 7'sd12 : -7'sd12;
      if (k % 7 == 3) rate_step = 7'sd5;
      @(negedge clk);
    end

    cur_req = "R6";
    rate_step = -7'sd16;
    gen_hi = 8; gen_per = 20;
    wait_clk(600);
    meas(pc, hc);
    near("R6", "newest capture period", pc, 5, NOM - MAX_STEP);
    near("R6", "newest capture high", hc, 2, NOM - MAX_STEP);

    cur_req = "R7";
    rate_step = '0;
    gen_hi = 20; gen_per = 40;
    wait_clk(400);
    gen_cycles = 0;
    wait_clk(1500);
    meas(pc, hc);
    chk(pc == 40, "R7", "repeat period", pc, 40);
    chk(hc == 20, "R7", "repeat high", hc, 20);
    meas(pc, hc);
    chk(pc == 40 && hc == 20, "R7", "second repeat high", hc, 20);

    cur_req = "R10";
    gen_hi = 8; gen_per = 40; gen_cycles = 1;
    wait_clk(400);
    meas(pc, hc);
    chk(pc == 40, "R10", "after overflow period", pc, 40);
    chk(hc == 20, "R10", "after overflow high", hc, 20);

    wait_clk(10);
    finish_run();
  end

endmodule